// File: doc/BRIEF.md
# Register Scoreboard Issue Control

This block decides, cycle by cycle, whether the instruction at the head of issue may enter one of three execution pipelines. It keeps one busy flag for every general-purpose register. An instruction names two source registers, one destination register and a target unit. It is held back while any of those registers still waits for a result. Otherwise it issues in the same cycle, and its destination is flagged busy from the next cycle.

Each pipeline has a fixed depth: 3 cycles for the integer unit, 5 for the floating-point adder and 6 for the floating-point multiplier. The pipeline carries the destination index as a tag. When the tag leaves the last stage, the pipeline raises a writeback strobe for that register, and the busy flag is dropped on the following edge. The units have different depths, so an independent instruction may issue and finish while a slower operation is still in flight. Register 0 is constant zero and never takes part in a hazard.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset every busy flag is 0 and no writeback strobe is active.
- R2: A request with no hazard and a valid unit code gets `issue_ok` high in the same cycle, and its destination flag reads 1 from the next cycle.
- R3: A request stalls (`issue_ok` low) while either source register, other than register 0, is flagged busy.
- R4: A request stalls while its destination register, other than register 0, is flagged busy.
- R5: Register 0 never reads busy and never causes a stall, even when it is issued as a destination.
- R6: Unit code 0 (integer) issued in cycle T raises `wb_vld[0]` in cycle T+3, with its destination on `wb_reg[4:0]`. The destination flag is clear from T+4.
- R7: Unit code 1 (floating add) issued in cycle T raises `wb_vld[1]` in cycle T+5, with its destination on `wb_reg[9:5]`. The flag is clear from T+6.
- R8: Unit code 2 (floating multiply) issued in cycle T raises `wb_vld[2]` in cycle T+6, with its destination on `wb_reg[14:10]`. The flag is clear from T+7.
- R9: A source that matches a register being written back in the current cycle still stalls, because there is no bypass. The instruction issues one cycle later.
- R10: When several units write back in the same cycle, every one of their flags is cleared on that edge.
- R11: An instruction that is independent of a pending operation issues while that operation is still in flight.
- R12: Unit code 3 is reserved. Such a request never issues and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An instruction is requesting issue; held until accepted |
| req_unit | input | 2 | Target unit: 0 integer, 1 float add, 2 float multiply, 3 reserved |
| req_src_a | input | 5 | First source register index |
| req_src_b | input | 5 | Second source register index |
| req_dst | input | 5 | Destination register index |
| issue_ok | output | 1 | The request is accepted in this cycle |
| busy_vec | output | 32 | Current busy flag of every register |
| wb_vld | output | 3 | Writeback strobe of each unit (bit = unit code) |
| wb_reg | output | 15 | Writeback register index of each unit, 5 bits per unit, unit 0 lowest |

## Verification
The bench goes after the exact writeback cycle of each unit depth. A pipeline that is one stage off would strobe a cycle early or late, and it would free a register before its result exists. It also presents a dependent source in the writeback cycle itself. A design that bypassed or cleared early would issue one cycle too soon there. Other tests stall on the destination alone and make all three units retire in one cycle. A shared clear port would then leave a flag stuck, and a design that ignored the destination would issue a second write to the same register. The remaining checks confirm that register 0 and the reserved unit code never disturb the flags.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        UNIT_INT  = 2'd0,
        UNIT_FADD = 2'd1,
        UNIT_FMUL = 2'd2,
        UNIT_NONE = 2'd3
    } unit_e;

    localparam int NUM_UNITS = 3;
endpackage

// File: rtl/sb_lat_pipe.sv
module sb_lat_pipe #(
    parameter int DEPTH = 3,
    parameter int IDXW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [IDXW-1:0] in_idx,
    output logic            out_vld,
    output logic [IDXW-1:0] out_idx
);
    logic [DEPTH-1:0] vld_q;
    logic [IDXW-1:0]  idx_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) idx_q[i] <= '0;
        end else begin
            vld_q[0] <= in_vld;
            idx_q[0] <= in_idx;
            for (int i = 1; i < DEPTH; i++) begin
                vld_q[i] <= vld_q[i-1];
                idx_q[i] <= idx_q[i-1];
            end
        end
    end

    assign out_vld = vld_q[DEPTH-1];
    assign out_idx = idx_q[DEPTH-1];
endmodule

// File: rtl/sb_busy_table.sv
module sb_busy_table #(
    parameter int NREGS  = 32,
    parameter int NPORTS = 3,
    localparam int IDXW  = $clog2(NREGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic [IDXW-1:0]        set_idx,
    input  logic [NPORTS-1:0]      clr_en,
    input  logic [NPORTS*IDXW-1:0] clr_idx,
    input  logic [IDXW-1:0]        rd_a,
    input  logic [IDXW-1:0]        rd_b,
    input  logic [IDXW-1:0]        rd_d,
    output logic [NREGS-1:0]       busy_q,
    output logic                   hazard
);
    logic [NREGS-1:0] busy_d;
    logic hz_a, hz_b, hz_d;

    always_comb begin
        busy_d = busy_q;
        for (int u = 0; u < NPORTS; u++) begin
            if (clr_en[u]) busy_d[clr_idx[u*IDXW +: IDXW]] = 1'b0;
        end
        if (set_en) busy_d[set_idx] = 1'b1;
        busy_d[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    always_comb begin
        hz_a   = (rd_a != '0) && busy_q[rd_a];
        hz_b   = (rd_b != '0) && busy_q[rd_b];
        hz_d   = (rd_d != '0) && busy_q[rd_d];
        hazard = hz_a || hz_b || hz_d;
    end

    // R5
    zero_reg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q[0]);

    // R2
    set_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_idx != '0) |=> busy_q[$past(set_idx)]);

    for (genvar u = 0; u < NPORTS; u++) begin : g_port_chk
        // R6
        wb_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en[u] && clr_idx[u*IDXW +: IDXW] != '0) |-> busy_q[clr_idx[u*IDXW +: IDXW]]);
        // R10
        clr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en[u] && clr_idx[u*IDXW +: IDXW] != '0) |=> !busy_q[$past(clr_idx[u*IDXW +: IDXW])]);
    end
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
    import sb_pkg::*;
#(
    parameter int NREGS    = 32,
    parameter int LAT_INT  = 3,
    parameter int LAT_FADD = 5,
    parameter int LAT_FMUL = 6,
    localparam int IDXW    = $clog2(NREGS),
    localparam int NU      = NUM_UNITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_unit,
    input  logic [IDXW-1:0]    req_src_a,
    input  logic [IDXW-1:0]    req_src_b,
    input  logic [IDXW-1:0]    req_dst,
    output logic               issue_ok,
    output logic [NREGS-1:0]   busy_vec,
    output logic [NU-1:0]      wb_vld,
    output logic [NU*IDXW-1:0] wb_reg
);
    logic hazard;
    logic unit_ok;

    assign unit_ok  = (unit_e'(req_unit) != UNIT_NONE);
    assign issue_ok = req_valid && unit_ok && !hazard;

    sb_busy_table #(
        .NREGS  (NREGS),
        .NPORTS (NU)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (issue_ok),
        .set_idx (req_dst),
        .clr_en  (wb_vld),
        .clr_idx (wb_reg),
        .rd_a    (req_src_a),
        .rd_b    (req_src_b),
        .rd_d    (req_dst),
        .busy_q  (busy_vec),
        .hazard  (hazard)
    );

    for (genvar u = 0; u < NU; u++) begin : g_unit
        localparam int LAT = (u == 0) ? LAT_INT : (u == 1) ? LAT_FADD : LAT_FMUL;
        sb_lat_pipe #(
            .DEPTH (LAT),
            .IDXW  (IDXW)
        ) pipe_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (issue_ok && (req_unit == 2'(u))),
            .in_idx  (req_dst),
            .out_vld (wb_vld[u]),
            .out_idx (wb_reg[u*IDXW +: IDXW])
        );
    end

    // R3
    src_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && req_src_a != '0) |-> !busy_vec[req_src_a]);

    // R4
    dst_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && req_dst != '0) |-> !busy_vec[req_dst]);

    // R12
    reserved_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_unit == 2'd3) |-> !issue_ok);
endmodule

// File: tb/sb_issue_ctrl_tb_top.sv
`timescale 1ns/1ps
module sb_issue_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_unit = 2'd0;
    logic [4:0]  req_src_a = 5'd0;
    logic [4:0]  req_src_b = 5'd0;
    logic [4:0]  req_dst = 5'd0;
    logic        issue_ok;
    logic [31:0] busy_vec;
    logic [2:0]  wb_vld;
    logic [14:0] wb_reg;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    sb_issue_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_unit  (req_unit),
        .req_src_a (req_src_a),
        .req_src_b (req_src_b),
        .req_dst   (req_dst),
        .issue_ok  (issue_ok),
        .busy_vec  (busy_vec),
        .wb_vld    (wb_vld),
        .wb_reg    (wb_reg)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic v, input int u, input int a, input int b, input int d);
        req_valid = v;
        req_unit  = 2'(u);
        req_src_a = 5'(a);
        req_src_b = 5'(b);
        req_dst   = 5'(d);
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        tick();
        chk("R1 busy after reset", busy_vec, 32'h0);
        chk("R1 wb after reset", 32'(wb_vld), 32'h0);
    endtask

    task automatic t_latency(input int u, input int d, input int lat, input string rq);
        tick();
        drive(1'b1, u, 0, 0, d);
        chk({rq, " / R2 issue"}, 32'(issue_ok), 32'd1);
        for (int k = 1; k <= lat + 1; k++) begin
            tick();
            if (k == 1) idle();
            else #1;
            chk({rq, " wb strobe"}, 32'(wb_vld[u]), 32'(k == lat));
            if (k == lat) chk({rq, " wb index"}, 32'(wb_reg[u*5 +: 5]), 32'(d));
            chk({rq, " / R2 busy flag"}, 32'(busy_vec[d]), 32'(k <= lat));
        end
    endtask

    task automatic t_src_stall();
        tick();
        drive(1'b1, 0, 0, 0, 7);
        for (int k = 1; k <= 4; k++) begin
            tick();
            drive(1'b1, 0, 7, 0, 8);
            chk("R3 src_a stall", 32'(issue_ok), 32'(k == 4));
            if (k == 3) begin
                chk("R9 wb cycle", 32'(wb_vld[0]), 32'd1);
                chk("R9 no bypass", 32'(issue_ok), 32'd0);
            end
        end
        tick(); idle();
        repeat (4) tick();
        tick();
        drive(1'b1, 1, 0, 0, 9);
        tick();
        drive(1'b1, 0, 0, 9, 10);
        chk("R3 src_b stall", 32'(issue_ok), 32'd0);
        tick(); idle();
        chk("R3 stalled dst not flagged", 32'(busy_vec[10]), 32'd0);
        repeat (6) tick();
        chk("R3 drained", busy_vec, 32'h0);
    endtask

    task automatic t_dst_stall();
        tick();
        drive(1'b1, 2, 0, 0, 10);
        for (int k = 1; k <= 7; k++) begin
            tick();
            drive(1'b1, 0, 0, 0, 10);
            chk("R4 dst stall", 32'(issue_ok), 32'(k == 7));
        end
        tick(); idle();
        repeat (4) tick();
        chk("R4 drained", busy_vec, 32'h0);
    endtask

    task automatic t_zero_reg();
        tick();
        drive(1'b1, 0, 0, 0, 0);
        chk("R5 issue to r0", 32'(issue_ok), 32'd1);
        tick();
        drive(1'b1, 0, 0, 0, 0);
        chk("R5 r0 back-to-back", 32'(issue_ok), 32'd1);
        chk("R5 r0 not busy", busy_vec, 32'h0);
        tick();
        drive(1'b1, 0, 0, 0, 3);
        chk("R5 r0 source", 32'(issue_ok), 32'd1);
        tick(); idle();
        chk("R5 only r3 busy", busy_vec, 32'h8);
        repeat (4) tick();
    endtask

    task automatic t_overlap();
        tick();
        drive(1'b1, 2, 0, 0, 11);
        chk("R11 slow issue", 32'(issue_ok), 32'd1);
        tick();
        drive(1'b1, 0, 1, 2, 12);
        chk("R11 int under fmul", 32'(issue_ok), 32'd1);
        tick();
        drive(1'b1, 1, 0, 0, 13);
        chk("R11 fadd under fmul", 32'(issue_ok), 32'd1);
        for (int k = 3; k <= 8; k++) begin
            tick();
            if (k == 3) idle();
            else #1;
            chk("R11 int wb", 32'(wb_vld[0]), 32'(k == 4));
            chk("R11 fmul wb", 32'(wb_vld[2]), 32'(k == 6));
            chk("R11 fadd wb", 32'(wb_vld[1]), 32'(k == 7));
            chk("R11 r11 busy", 32'(busy_vec[11]), 32'(k <= 6));
            chk("R11 r12 busy", 32'(busy_vec[12]), 32'(k <= 4));
        end
        tick();
    endtask

    task automatic t_simul_wb();
        tick();
        drive(1'b1, 2, 0, 0, 20);
        chk("R10 fmul issue", 32'(issue_ok), 32'd1);
        for (int k = 1; k <= 7; k++) begin
            tick();
            if (k == 1) begin
                drive(1'b1, 1, 0, 0, 21);
                chk("R10 fadd issue", 32'(issue_ok), 32'd1);
            end else if (k == 3) begin
                drive(1'b1, 0, 0, 0, 22);
                chk("R10 int issue", 32'(issue_ok), 32'd1);
            end else idle();
            if (k == 6) begin
                chk("R10 all strobes", 32'(wb_vld), 32'h7);
                chk("R10 indices", 32'(wb_reg), 32'({5'd20, 5'd21, 5'd22}));
            end
            if (k == 7) chk("R10 all cleared", busy_vec, 32'h0);
        end
    endtask

    task automatic t_bad_unit();
        tick();
        drive(1'b1, 3, 0, 0, 15);
        chk("R12 reserved unit", 32'(issue_ok), 32'd0);
        tick();
        drive(1'b1, 3, 0, 0, 15);
        chk("R12 reserved unit held", 32'(issue_ok), 32'd0);
        for (int k = 1; k <= 7; k++) begin
            tick();
            if (k == 1) idle();
            else #1;
            chk("R12 no wb", 32'(wb_vld), 32'h0);
            chk("R12 no flag", busy_vec, 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_latency(0, 5, 3, "R6");
        t_latency(1, 6, 5, "R7");
        t_latency(2, 17, 6, "R8");
        t_src_stall();
        t_dst_stall();
        t_zero_reg();
        t_overlap();
        t_simul_wb();
        t_bad_unit();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule